// File: doc/BRIEF.md
# Read Delay Leveling Unit

This block equalizes read latency across every device sharing a memory channel. Earlier steps take each device's read domain, which is its round-trip propagation delay in clock cycles, and hand it to the unit one device at a time. The unit collects every domain first. It then takes the largest one as the common total latency. For each device it computes the extra programmed delay that makes propagation delay plus programmed delay equal that total.

The per-device results leave through a valid/ready stream in device-ID order. Each beat carries the device ID, the programmed delay to be written into that device's two timing registers, and an error flag. An updated controller read offset replaces the earlier minimum value once every domain has been collected. A one-cycle `done` pulse marks the end of a run.

Back-pressure rules:
- On the input side, `in_ready` is high only while the unit is gathering domains. A beat transfers on any cycle where `in_valid` and `in_ready` are both high.
- On the output side, a beat transfers when `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, every output field holds its value.
- The two directions are never active in the same cycle.

Top module: `rdlvl_unit`

## Requirements
- R1: After reset, `in_ready`, `out_valid`, `done` and `busy` are 0, and `rd_offset` is 0.
- R2: In idle, a `start` pulse with `dev_count` in 1..MAX_DEV raises `in_ready` and `busy` on the next cycle. A `start` pulse with `dev_count` equal to 0 or above MAX_DEV is ignored: `in_ready` and `busy` stay 0.
- R3: Exactly `dev_count` domains are accepted, one per input handshake, stored in order as device 0, 1, 2 and so on. `out_valid` stays 0 until the last domain is taken. `in_ready` falls in the cycle after the last input handshake.
- R4: In the cycle after the last input handshake, `rd_offset` equals the largest domain of the run. It holds that value until a later run completes its collection.
- R5: Output beats appear in device-ID order 0..`dev_count`-1, exactly one beat per device. For a device with domain d in a run whose largest domain is M, `out_delay` = M − d.
- R6: When M − d exceeds 2^DLY_W − 1, `out_err` is 1 and `out_delay` is all ones. Otherwise `out_err` is 0.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_dev_id`, `out_delay` and `out_err` hold their values on the next cycle.
- R8: `done` is 1 for exactly one cycle, the cycle after the final output handshake. In that cycle `busy` is already 0.
- R9: A `start` pulse received while a run is in progress is ignored. The run continues and completes with unchanged results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a leveling run |
| dev_count | input | ID_W+1 | Number of devices in the run, sampled with `start` |
| in_valid | input | 1 | Measured domain is present |
| in_ready | output | 1 | Unit accepts a domain |
| in_domain | input | DOM_W | Measured read domain, in cycles |
| out_valid | output | 1 | Result beat is present |
| out_ready | input | 1 | Consumer takes the result beat |
| out_dev_id | output | ID_W | Device the beat belongs to |
| out_delay | output | DLY_W | Programmed delay for that device |
| out_err | output | 1 | Required delay exceeds the field range |
| rd_offset | output | DOM_W | Updated controller read offset (total latency) |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse after the final result |

## Verification
The bench covers several boundary runs:
- A single-device run has to give a zero delay. A design that subtracted against a stale or cleared peak would report a non-zero value.
- A run over all 32 devices has spreads above the field range. Missing saturation shows up as a wrapped delay with no error flag.
- A stalled consumer must see frozen beats. A design that advanced its index on `out_valid` alone would skip devices.
- Out-of-range counts and a `start` injected mid-collection must both be ignored. A design that restarted would shift every device's result by one slot.
- A second run with a smaller peak checks that `rd_offset` is replaced and not merged with the earlier value.

// File: rtl/rdlvl_pkg.sv
package rdlvl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_GATHER = 2'd1,
    ST_ISSUE  = 2'd2
  } lvl_state_e;
endpackage

// File: rtl/rdlvl_store.sv
module rdlvl_store #(
  parameter int DEPTH = 32,
  parameter int DW    = 5,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wr_data;
  end

  assign rd_data = mem[addr];
endmodule

// File: rtl/rdlvl_peak.sv
module rdlvl_peak #(
  parameter int DW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          upd,
  input  logic [DW-1:0] sample,
  output logic [DW-1:0] peak_nxt,
  output logic [DW-1:0] peak_q
);
  always_comb begin
    peak_nxt = peak_q;
    if (upd && (sample > peak_q)) peak_nxt = sample;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     peak_q <= '0;
    else if (clear) peak_q <= '0;
    else if (upd)   peak_q <= peak_nxt;
  end

  // R4
  peak_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !clear) |=> (peak_q >= $past(sample)));
endmodule

// File: rtl/rdlvl_comp.sv
module rdlvl_comp #(
  parameter int DOM_W = 5,
  parameter int DLY_W = 3
) (
  input  logic [DOM_W-1:0] target,
  input  logic [DOM_W-1:0] domain,
  output logic [DLY_W-1:0] delay,
  output logic             err
);
  localparam logic [DOM_W-1:0] DLY_MAX = DOM_W'((1 << DLY_W) - 1);

  logic [DOM_W-1:0] diff;

  always_comb begin
    diff  = target - domain;
    err   = (diff > DLY_MAX);
    delay = err ? {DLY_W{1'b1}} : diff[DLY_W-1:0];
  end

  // R6
  always_comb begin
    sat_field_chk: assert (!err || (&delay));
  end
endmodule

// File: rtl/rdlvl_ctrl.sv
module rdlvl_ctrl
  import rdlvl_pkg::*;
#(
  parameter int MAX_DEV = 32,
  parameter int ID_W    = 5,
  parameter int CNT_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] dev_count,
  input  logic             in_valid,
  input  logic             out_ready,
  output logic             in_ready,
  output logic             out_valid,
  output logic [ID_W-1:0]  idx,
  output logic             accept,
  output logic             last_accept,
  output logic             clear,
  output logic             busy,
  output logic             done
);
  lvl_state_e       state_q;
  logic [CNT_W-1:0] count_q;
  logic [ID_W-1:0]  idx_q;
  logic             done_q;
  logic             cnt_ok;
  logic             at_last;
  logic             fire;

  assign cnt_ok      = (dev_count != '0) && (dev_count <= CNT_W'(MAX_DEV));
  assign at_last     = ({1'b0, idx_q} == (count_q - CNT_W'(1)));
  assign in_ready    = (state_q == ST_GATHER);
  assign out_valid   = (state_q == ST_ISSUE);
  assign accept      = in_ready && in_valid;
  assign last_accept = accept && at_last;
  assign fire        = out_valid && out_ready;
  assign clear       = (state_q == ST_IDLE) && start && cnt_ok;
  assign busy        = (state_q != ST_IDLE);
  assign idx         = idx_q;
  assign done        = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      count_q <= '0;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start && cnt_ok) begin
            count_q <= dev_count;
            idx_q   <= '0;
            state_q <= ST_GATHER;
          end
        end
        ST_GATHER: begin
          if (accept) begin
            if (at_last) begin
              idx_q   <= '0;
              state_q <= ST_ISSUE;
            end else begin
              idx_q <= idx_q + ID_W'(1);
            end
          end
        end
        ST_ISSUE: begin
          if (fire) begin
            if (at_last) begin
              idx_q   <= '0;
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              idx_q <= idx_q + ID_W'(1);
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R3
  dir_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  // R7
  hold_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(idx)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && start && !in_valid) |=> (in_ready && $stable(idx)));
endmodule

// File: rtl/rdlvl_unit.sv
module rdlvl_unit
  import rdlvl_pkg::*;
#(
  parameter int MAX_DEV = 32,
  parameter int DOM_W   = 5,
  parameter int DLY_W   = 3,
  localparam int ID_W   = (MAX_DEV > 1) ? $clog2(MAX_DEV) : 1,
  localparam int CNT_W  = ID_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] dev_count,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DOM_W-1:0] in_domain,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [ID_W-1:0]  out_dev_id,
  output logic [DLY_W-1:0] out_delay,
  output logic             out_err,
  output logic [DOM_W-1:0] rd_offset,
  output logic             busy,
  output logic             done
);
  logic             accept;
  logic             last_accept;
  logic             clear;
  logic [ID_W-1:0]  idx;
  logic [DOM_W-1:0] stored_dom;
  logic [DOM_W-1:0] peak_nxt;
  logic [DOM_W-1:0] peak_q;
  logic [DOM_W-1:0] ofs_q;

  rdlvl_ctrl #(
    .MAX_DEV (MAX_DEV),
    .ID_W    (ID_W),
    .CNT_W   (CNT_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .dev_count   (dev_count),
    .in_valid    (in_valid),
    .out_ready   (out_ready),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .idx         (idx),
    .accept      (accept),
    .last_accept (last_accept),
    .clear       (clear),
    .busy        (busy),
    .done        (done)
  );

  rdlvl_store #(
    .DEPTH (MAX_DEV),
    .DW    (DOM_W),
    .AW    (ID_W)
  ) u_store (
    .clk     (clk),
    .wr_en   (accept),
    .addr    (idx),
    .wr_data (in_domain),
    .rd_data (stored_dom)
  );

  rdlvl_peak #(
    .DW (DOM_W)
  ) u_peak (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .upd      (accept),
    .sample   (in_domain),
    .peak_nxt (peak_nxt),
    .peak_q   (peak_q)
  );

  rdlvl_comp #(
    .DOM_W (DOM_W),
    .DLY_W (DLY_W)
  ) u_comp (
    .target (peak_q),
    .domain (stored_dom),
    .delay  (out_delay),
    .err    (out_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           ofs_q <= '0;
    else if (last_accept) ofs_q <= peak_nxt;
  end

  assign rd_offset  = ofs_q;
  assign out_dev_id = idx;

  // R5
  target_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (peak_q >= stored_dom));

  // R7
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> ($stable(out_delay) && $stable(out_err)));

  // R4
  ofs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !last_accept |=> $stable(rd_offset));

  // R4
  ofs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (rd_offset == peak_q));
endmodule

// File: tb/rdlvl_unit_bench.sv
module rdlvl_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [5:0] dev_count = '0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [4:0] in_domain = '0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [4:0] out_dev_id;
  logic [2:0] out_delay;
  logic       out_err;
  logic [4:0] rd_offset;
  logic       busy;
  logic       done;

  int n_tests = 0;
  int n_fail  = 0;
  logic [4:0] dom_tb [32];

  always #5 clk = ~clk;

  rdlvl_unit u_rdlvl_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .dev_count(dev_count),
    .in_valid(in_valid), .in_ready(in_ready), .in_domain(in_domain),
    .out_valid(out_valid), .out_ready(out_ready), .out_dev_id(out_dev_id),
    .out_delay(out_delay), .out_err(out_err), .rd_offset(rd_offset),
    .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // full run: start, gather (optional gaps / mid-run start), drain (optional stalls)
  task automatic run_level(input int cnt, input bit gap, input bit stall,
                           input bit poke, input string tag);
    int exp_max = 0;
    for (int i = 0; i < cnt; i++) if (dom_tb[i] > exp_max) exp_max = dom_tb[i];
    @(negedge clk);
    start = 1'b1; dev_count = 6'(cnt);
    @(negedge clk);
    start = 1'b0;
    chk(in_ready == 1'b1 && busy == 1'b1, {tag, " R2 start accepted"}, int'(in_ready), 1);
    for (int i = 0; i < cnt; i++) begin
      if (gap && i[0]) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1; in_domain = dom_tb[i];
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      if (i == 0 && cnt > 1) begin
        chk(out_valid == 1'b0, {tag, " R3 no output mid-gather"}, int'(out_valid), 0);
        if (poke) begin
          start = 1'b1; dev_count = 6'd1;
          @(negedge clk);
          start = 1'b0;
          chk(in_ready == 1'b1 && busy == 1'b1, {tag, " R9 start ignored while busy"},
              int'(in_ready), 1);
        end
      end
    end
    chk(in_ready == 1'b0 && out_valid == 1'b1, {tag, " R3 gather closed"}, int'(in_ready), 0);
    chk(rd_offset == 5'(exp_max), {tag, " R4 rd_offset"}, int'(rd_offset), exp_max);
    for (int i = 0; i < cnt; i++) begin
      int diff = exp_max - int'(dom_tb[i]);
      bit e_err = (diff > 7);
      int e_dly = e_err ? 7 : diff;
      if (stall) begin
        logic [4:0] id0;
        logic [2:0] d0;
        out_ready = 1'b0;
        id0 = out_dev_id; d0 = out_delay;
        @(negedge clk);
        chk(out_valid && out_dev_id == id0 && out_delay == d0,
            {tag, " R7 held under stall"}, int'(out_dev_id), int'(id0));
      end
      while (!out_valid) @(negedge clk);
      chk(out_dev_id == 5'(i), {tag, " R5 id order"}, int'(out_dev_id), i);
      chk(out_delay == 3'(e_dly), {tag, " R5 delay"}, int'(out_delay), e_dly);
      chk(out_err == e_err, {tag, " R6 err flag"}, int'(out_err), int'(e_err));
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
    end
    chk(done == 1'b1 && busy == 1'b0 && out_valid == 1'b0, {tag, " R8 done pulse"},
        int'(done), 1);
    @(negedge clk);
    chk(done == 1'b0, {tag, " R8 done single cycle"}, int'(done), 0);
  endtask

  task automatic t_reset();
    chk(!in_ready && !out_valid && !done && !busy, "R1 reset controls", int'(busy), 0);
    chk(rd_offset == 5'd0, "R1 reset rd_offset", int'(rd_offset), 0);
  endtask

  task automatic t_basic();
    dom_tb[0] = 5'd3; dom_tb[1] = 5'd6; dom_tb[2] = 5'd4; dom_tb[3] = 5'd5;
    run_level(4, 1'b1, 1'b0, 1'b0, "basic");
  endtask

  task automatic t_single();
    dom_tb[0] = 5'd9;
    run_level(1, 1'b0, 1'b0, 1'b0, "single");
  endtask

  task automatic t_full_stall();
    for (int i = 0; i < 32; i++) dom_tb[i] = 5'((i * 7 + 3) % 32);
    run_level(32, 1'b0, 1'b1, 1'b0, "full");
  endtask

  task automatic t_bad_start();
    logic [4:0] ofs0 = rd_offset;
    @(negedge clk);
    start = 1'b1; dev_count = 6'd0;
    @(negedge clk);
    start = 1'b0;
    chk(!in_ready && !busy, "R2 count zero ignored", int'(busy), 0);
    start = 1'b1; dev_count = 6'd33;
    @(negedge clk);
    start = 1'b0;
    chk(!in_ready && !busy, "R2 count over max ignored", int'(busy), 0);
    chk(rd_offset == ofs0, "R4 rd_offset held", int'(rd_offset), int'(ofs0));
  endtask

  task automatic t_busy_poke();
    dom_tb[0] = 5'd2; dom_tb[1] = 5'd1; dom_tb[2] = 5'd4;
    run_level(3, 1'b0, 1'b0, 1'b1, "poke");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_single();
    t_full_stall();
    t_bad_start();
    t_busy_poke();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule